// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words on a synchronous link where it drives the shift clock itself. A programmable 8-bit divider sets the clock rate. The receiver samples the data line on every falling edge of that clock and assembles 8-bit or 9-bit words, least significant bit first. Completed words go into a one-word holding register that the host empties with a read strobe.

Reception runs only while the port is enabled, set for synchronous operation and set as clock master. Two enables start it. A one-shot enable, armed by a pulse, fetches one word and then clears itself. A level enable keeps fetching words back to back for as long as it stays high. When both are active, the level enable governs.

A word that completes while the previous one is still unread is lost. In that case an overrun flag latches and stops the clock. The flag stays set until the level enable is taken from high to low.

Top module: `sync_master_rx`

## Requirements
- R1: The shift clock `sclk_o` toggles only when `port_en_i`, `sync_mode_i` and `master_i` are all 1, at least one receive enable is active, and `overrun_o` is 0. In every other case `sclk_o` is 0 from the next cycle on and no word is captured.
- R2: The shift clock period is 4×(`baud_div_i`+1) clock cycles. The first half of each period is low and the second half is high.
- R3: The data line is sampled at the clock edge where `sclk_o` falls. The first sample is word bit 0, and later samples fill bits in ascending order.
- R4: A one-cycle pulse on `single_set_i` sets `single_en_o`. The clock edge that captures the last bit of the next word clears it, and the shift clock then stays low while `cont_en_i` is 0.
- R5: While `cont_en_i` is 1, words are received back to back with no idle clock period between them. This also holds when `single_en_o` is set.
- R6: `rx_valid_o` rises, and `rx_data_o`/`rx_bit8_o` take the new word, at the clock edge that samples the word's last bit. A 1 on `rd_i` clears `rx_valid_o` on the next edge. A read with no word pending changes nothing else.
- R7: If a word completes while `rx_valid_o` is 1 and `rd_i` is 0, then `overrun_o` is set, the new word is dropped, the held data stays unchanged, and reception stops.
- R8: `overrun_o` clears on the clock edge after `cont_en_i` goes from 1 to 0.
- R9: Removing the active enable in the middle of a word abandons the partial word. The next word starts again from bit 0.
- R10: With `nine_bit_i` = 1, words are 9 bits long and the ninth bit appears on `rx_bit8_o`. With `nine_bit_i` = 0, words are 8 bits long and `rx_bit8_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Serial port enabled |
| sync_mode_i | input | 1 | Synchronous operation selected |
| master_i | input | 1 | Block drives the shift clock |
| single_set_i | input | 1 | Pulse arming a one-word reception |
| cont_en_i | input | 1 | Level enable for continuous reception |
| nine_bit_i | input | 1 | 1 selects 9-bit words |
| baud_div_i | input | 8 | Shift clock divider |
| rx_data_i | input | 1 | Serial data line |
| rd_i | input | 1 | Host read strobe, pops the held word |
| sclk_o | output | 1 | Generated shift clock, idles low |
| rx_data_o | output | 8 | Low eight bits of the held word |
| rx_bit8_o | output | 1 | Ninth bit of the held word |
| rx_valid_o | output | 1 | Receive-complete flag |
| overrun_o | output | 1 | Overrun error flag |
| single_en_o | output | 1 | One-word reception still pending |

## Verification
The shift clock is registered, so it goes high one cycle after its phase counter reaches the half period. Word capture, the receive-complete flag, the overrun flag and the clearing of `single_en_o` all take effect on the edge that samples the last bit. A read or a falling continuous enable acts on the following edge. The bench keeps a behavioural model that advances on each rising edge from the same inputs and compares every output against it on each falling edge, so each result is checked in the exact cycle it is due. Directed checks add fixed expected words, clock period and high time, and the overrun, abort and disabled-port cases.

// File: rtl/smrx_pkg.sv
package smrx_pkg;
  localparam int unsigned SMRX_BITS_MAX = 9;
  typedef logic [SMRX_BITS_MAX-1:0] smrx_word_t;
endpackage

// File: rtl/smrx_clkgen.sv
module smrx_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             samp_o
);
  localparam int unsigned CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cnt_q, cnt_n, last_c, half_m1;

  assign last_c  = {div_i, 2'b11};        // 4*(div+1)-1
  assign half_m1 = {1'b0, div_i, 1'b1};   // 2*(div+1)-1
  assign samp_o  = busy_i && (cnt_q == last_c);
  assign cnt_n   = samp_o ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (!busy_i) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      sclk_o <= cnt_n > half_m1;
    end
  end

  // sample strobe and falling clock must coincide
  assert_fall_at_sample_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) && $past(busy_i) |-> $past(samp_o));
endmodule

// File: rtl/smrx_shifter.sv
module smrx_shifter
  import smrx_pkg::*;
#(
  parameter int unsigned BITS_MAX = SMRX_BITS_MAX
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                busy_i,
  input  logic                samp_i,
  input  logic                nine_i,
  input  logic                rx_i,
  output logic                done_o,
  output logic [BITS_MAX-1:0] word_o
);
  localparam int unsigned IDX_W = $clog2(BITS_MAX);

  logic [IDX_W-1:0]    idx_q, last_idx;
  logic [BITS_MAX-1:0] sh_q;

  assign last_idx = nine_i ? IDX_W'(BITS_MAX - 1) : IDX_W'(BITS_MAX - 2);
  assign done_o   = samp_i && (idx_q == last_idx);

  always_comb begin
    word_o        = sh_q;
    word_o[idx_q] = rx_i;
    if (!nine_i) word_o[BITS_MAX-1] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sh_q  <= '0;
    end else if (!busy_i) begin
      idx_q <= '0;                         // partial word abandoned
    end else if (samp_i) begin
      sh_q  <= word_o;
      idx_q <= done_o ? '0 : idx_q + IDX_W'(1);
    end
  end

  assert_lsb_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && samp_i && (idx_q == '0) |=> sh_q[0] == $past(rx_i));
endmodule

// File: rtl/smrx_rxbuf.sv
module smrx_rxbuf
  import smrx_pkg::*;
#(
  parameter int unsigned BITS_MAX = SMRX_BITS_MAX
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                done_i,
  input  logic [BITS_MAX-1:0] word_i,
  input  logic                rd_i,
  input  logic                cont_fall_i,
  output logic [BITS_MAX-1:0] data_o,
  output logic                valid_o,
  output logic                ovr_o
);
  logic accept;
  assign accept = done_i && (!valid_o || rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      if (accept) begin
        data_o  <= word_i;
        valid_o <= 1'b1;
      end else if (rd_i) begin
        valid_o <= 1'b0;
      end
      if (cont_fall_i)                       ovr_o <= 1'b0;
      else if (done_i && valid_o && !rd_i)   ovr_o <= 1'b1;
    end
  end

  assert_rd_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !done_i |=> !valid_o);
  assert_overrun_keeps_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && valid_o && !rd_i |=> ovr_o && $stable(data_o));
  assert_ovr_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_fall_i |=> !ovr_o);
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
  import smrx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     port_en_i,
  input  logic                     sync_mode_i,
  input  logic                     master_i,
  input  logic                     single_set_i,
  input  logic                     cont_en_i,
  input  logic                     nine_bit_i,
  input  logic [DIV_W-1:0]         baud_div_i,
  input  logic                     rx_data_i,
  input  logic                     rd_i,
  output logic                     sclk_o,
  output logic [SMRX_BITS_MAX-2:0] rx_data_o,
  output logic                     rx_bit8_o,
  output logic                     rx_valid_o,
  output logic                     overrun_o,
  output logic                     single_en_o
);
  logic       busy, samp, word_done, cont_q, cont_fall;
  smrx_word_t word, held;

  assign cont_fall = cont_q && !cont_en_i;
  assign busy      = port_en_i && sync_mode_i && master_i
                  && (cont_en_i || single_en_o) && !overrun_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cont_q      <= 1'b0;
      single_en_o <= 1'b0;
    end else begin
      cont_q <= cont_en_i;
      if (single_set_i)   single_en_o <= 1'b1;
      else if (word_done) single_en_o <= 1'b0;
    end
  end

  smrx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i, .rst_ni, .busy_i(busy), .div_i(baud_div_i),
    .sclk_o, .samp_o(samp)
  );

  smrx_shifter #(.BITS_MAX(SMRX_BITS_MAX)) u_shifter (
    .clk_i, .rst_ni, .busy_i(busy), .samp_i(samp), .nine_i(nine_bit_i),
    .rx_i(rx_data_i), .done_o(word_done), .word_o(word)
  );

  smrx_rxbuf #(.BITS_MAX(SMRX_BITS_MAX)) u_rxbuf (
    .clk_i, .rst_ni, .done_i(word_done), .word_i(word), .rd_i,
    .cont_fall_i(cont_fall), .data_o(held), .valid_o(rx_valid_o), .ovr_o(overrun_o)
  );

  assign rx_data_o = held[SMRX_BITS_MAX-2:0];
  assign rx_bit8_o = held[SMRX_BITS_MAX-1];

  assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> !sclk_o);
  assert_single_stops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done && !single_set_i |=> !single_en_o);
  assert_overrun_halts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> !sclk_o);
endmodule

// File: tb/sync_master_rx_tb.sv
module sync_master_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic port_en = 0, sync_mode = 0, master = 0, single_set = 0, cont_en = 0;
  logic nine_bit = 0, rx_data = 0, rd = 0;
  logic [7:0] div = 8'd0;
  logic sclk, bit8, valid, ovr, single_en;
  logic [7:0] data;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;   // 250 MHz

  sync_master_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .sync_mode_i(sync_mode),
    .master_i(master), .single_set_i(single_set), .cont_en_i(cont_en),
    .nine_bit_i(nine_bit), .baud_div_i(div), .rx_data_i(rx_data), .rd_i(rd),
    .sclk_o(sclk), .rx_data_o(data), .rx_bit8_o(bit8), .rx_valid_o(valid),
    .overrun_o(ovr), .single_en_o(single_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt = 0, m_idx = 0, m_words = 0, base_words = 0;
  logic m_sclk = 0, m_valid = 0, m_ovr = 0, m_single = 0, m_cprev = 0;
  logic [8:0] m_word = 0, m_data = 0, word_base = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_idx = 0; m_sclk = 0; m_valid = 0; m_ovr = 0;
      m_single = 0; m_cprev = 0; m_data = 0;
    end else begin
      int per, nb;
      logic en_ok, busy, samp, done, v_old;
      per   = 4 * (int'(div) + 1);
      nb    = nine_bit ? 9 : 8;
      en_ok = port_en && sync_mode && master;
      busy  = en_ok && (cont_en || m_single) && !m_ovr;
      samp  = busy && (m_cnt == per - 1);
      done  = 0;
      v_old = m_valid;
      if (samp) begin
        m_word[m_idx] = rx_data;
        done = (m_idx == nb - 1);
      end
      if (done && (!v_old || rd)) begin
        m_data  = nine_bit ? m_word : (m_word & 9'h0FF);
        m_valid = 1;
      end else if (rd) m_valid = 0;
      if (m_cprev && !cont_en) m_ovr = 0;
      else if (done && v_old && !rd) m_ovr = 1;
      if (single_set) m_single = 1;
      else if (done) m_single = 0;
      if (!busy) begin
        m_cnt = 0; m_idx = 0; m_sclk = 0;
      end else begin
        m_cnt  = samp ? 0 : m_cnt + 1;
        m_sclk = (m_cnt >= per / 2);
        if (samp) m_idx = done ? 0 : m_idx + 1;
      end
      if (done) m_words++;
      m_cprev = cont_en;
    end
  end

  // compare every cycle, then drive the slave data bit
  always @(negedge clk) begin
    logic [8:0] pat;
    chk("R2 sclk", int'(sclk), int'(m_sclk));
    chk("R6 valid", int'(valid), int'(m_valid));
    chk("R3 data", int'(data), int'(m_data[7:0]));
    chk("R10 bit8", int'(bit8), int'(m_data[8]));
    chk("R7 overrun", int'(ovr), int'(m_ovr));
    chk("R4 single_en", int'(single_en), int'(m_single));
    pat = word_base + 9'((m_words - base_words) * 'h5B);
    rx_data <= pat[m_idx];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_single();
    @(negedge clk) single_set = 1;
    @(negedge clk) single_set = 0;
  endtask
  task automatic pulse_rd();
    @(negedge clk) rd = 1;
    @(negedge clk) rd = 0;
  endtask
  task automatic wait_valid(input int max);
    for (int i = 0; i < max && !valid; i++) @(negedge clk);
  endtask
  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sclk) hi++;
    end
  endtask
  task automatic new_base(input logic [8:0] b);
    word_base = b; base_words = m_words;
  endtask

  initial begin
    int hi, per;
    wait_n(3);
    chk("R1 reset sclk", int'(sclk), 0);
    chk("R6 reset valid", int'(valid), 0);
    chk("R7 reset overrun", int'(ovr), 0);
    @(negedge clk) rst_n = 1;
    port_en = 1; sync_mode = 1; master = 1;

    // single 8-bit word, pattern bit 8 set but ignored
    new_base(9'h1A5); div = 0;
    pulse_single();
    wait_n(40);
    chk("R4 single cleared", int'(single_en), 0);
    chk("R6 valid set", int'(valid), 1);
    chk("R3 word", int'(data), 'hA5);
    chk("R10 bit8 zero in 8-bit mode", int'(bit8), 0);
    count_high(20, hi);
    chk("R4 clock stopped", hi, 0);
    pulse_rd();
    chk("R6 read clears", int'(valid), 0);
    pulse_rd();
    chk("R6 empty read no effect valid", int'(valid), 0);
    chk("R6 empty read no effect data", int'(data), 'hA5);

    // single 9-bit word
    new_base(9'h1C3); div = 2; nine_bit = 1;
    pulse_single();
    wait_valid(200);
    chk("R10 ninth bit", int'(bit8), 1);
    chk("R3 9-bit word low", int'(data), 'hC3);
    pulse_rd();
    nine_bit = 0;

    // clock period and high time
    div = 3; new_base(9'h05A);
    pulse_single();
    while (!sclk) @(negedge clk);
    hi = 0; per = 0;
    while (sclk) begin hi++; per++; @(negedge clk); end
    while (!sclk) begin per++; @(negedge clk); end
    chk("R2 high time", hi, 8);
    chk("R2 period", per, 16);
    wait_valid(200);
    chk("R3 word div3", int'(data), 'h5A);
    pulse_rd();

    // continuous, three words read promptly, then abort mid-word
    div = 1; new_base(9'h13C);
    @(negedge clk) cont_en = 1;
    for (int k = 0; k < 3; k++) begin
      logic [8:0] e;
      e = 9'h13C + 9'(k * 'h5B);
      wait_valid(200);
      chk("R5 back-to-back word", int'(data), int'(e[7:0]));
      pulse_rd();
    end
    wait_n(20);
    @(negedge clk) cont_en = 0;
    wait_n(2);
    chk("R9 abort stops clock", int'(sclk), 0);
    chk("R9 abort no word", int'(valid), 0);
    new_base(9'h03C);
    pulse_single();
    wait_valid(200);
    chk("R9 restart from bit 0", int'(data), 'h3C);
    pulse_rd();

    // both enables: continuous wins
    div = 0; new_base(9'h066);
    @(negedge clk) begin cont_en = 1; single_set = 1; end
    @(negedge clk) single_set = 0;
    wait_valid(100);
    chk("R5 first word both set", int'(data), 'h66);
    pulse_rd();
    chk("R5 single cleared", int'(single_en), 0);
    count_high(16, hi);
    chk("R5 clock continues", int'(hi > 0), 1);
    @(negedge clk) cont_en = 0;
    wait_n(4);
    if (valid) pulse_rd();

    // overrun
    new_base(9'h0B7);
    @(negedge clk) cont_en = 1;
    wait_n(80);
    chk("R7 overrun set", int'(ovr), 1);
    chk("R7 first word kept", int'(data), 'hB7);
    count_high(20, hi);
    chk("R7 reception halted", hi, 0);
    pulse_rd();
    chk("R7 overrun survives read", int'(ovr), 1);
    count_high(10, hi);
    chk("R1 no clock while overrun", hi, 0);
    @(negedge clk) cont_en = 0;
    @(negedge clk);
    chk("R8 overrun cleared", int'(ovr), 0);

    // not clock master
    master = 0;
    @(negedge clk) cont_en = 1;
    count_high(50, hi);
    chk("R1 disabled no clock", hi, 0);
    chk("R1 disabled no word", int'(valid), 0);
    @(negedge clk) cont_en = 0;
    master = 1;
    wait_n(5);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule